// File: doc/BRIEF.md
# Timing-Error Replay Controller With Escalation

This controller recovers from a timing error without ever touching the core clock. The write-back stage reports an error for an instruction. The controller then stalls normal issue and sends the faulty instruction back into the pipeline several times in a row. It emits one copy per cycle. Every copy except the last carries a replica tag, so it cannot write architectural state. Those copies exist only to let the stage inputs settle. The last copy carries the valid tag and may commit. Each copy also carries a sequence tag. Write-back returns that tag with its error flag, so the controller can tell which issue a result belongs to.

The number of copies N is a register that software can write. If the valid copy fails, the controller replays the instruction a second time, now with as many copies as the pipeline has stages. If that escalated attempt also fails, the controller sets a sticky fatal bit and releases the pipeline. Three counters track accepted errors, escalations and the cycles spent in recovery.

The state machine has three states:
- `RS_IDLE` (normal operation).
- `RS_ISSUE` (one copy per cycle).
- `RS_WAIT` (awaiting the valid copy's result).

It has these transitions:
- **trigger**: `RS_IDLE` to `RS_ISSUE` on an error from write-back.
- **last copy**: `RS_ISSUE` to `RS_WAIT` after the final copy.
- **clean**: `RS_WAIT` to `RS_IDLE` when the valid copy returns without error.
- **escalate**: `RS_WAIT` to `RS_ISSUE` when the first attempt's valid copy fails.
- **fatal**: `RS_WAIT` to `RS_IDLE` when the escalated attempt's valid copy fails.

Top module: `rpl_ctrl`

## Requirements
- R1: After reset the controller is in `RS_IDLE`. `stall_o`, `rpl_fire`, `rpl_replica` and `fatal_o` are 0, all three counters are 0, the next sequence tag is 0 and N is 2.
- R2: A write of `n_wdata` stores 1 when the value is 0, stores DEPTH (default 5) when the value is above DEPTH, and stores the value unchanged otherwise.
- R3: When `wb_vld` and `wb_err` are both high in `RS_IDLE`, the next cycle begins a recovery. `stall_o` is high from that cycle until the recovery ends. `rpl_fire` is high for exactly N consecutive cycles with no gap.
- R4: Within one attempt, the first N-1 copies have `rpl_replica`=1 and the last copy has `rpl_replica`=0. With N=1 the only copy is valid.
- R5: Each copy carries `rpl_seq`. The tag starts at 0 after reset and rises by one per copy, wrapping modulo 2^SEQ_W.
- R6: After the last copy, `rpl_fire` is 0 and `stall_o` stays 1. The controller waits for a write-back result whose `wb_seq` equals the valid copy's tag. If that result has `wb_err`=0, `stall_o` is 0 in the next cycle.
- R7: In `RS_WAIT`, a write-back result whose tag is not the valid copy's tag is discarded. It does not end or escalate the recovery and it does not change any counter, even when it carries an error.
- R8: If the valid copy of the first attempt returns with an error, a second attempt of exactly DEPTH copies (DEPTH-1 replicas) starts in the next cycle, and `esc_cnt` rises by one.
- R9: If the valid copy of the escalated attempt returns with an error, `fatal_o` becomes 1 and the controller returns to `RS_IDLE`. `fatal_o` stays 1 until reset, through any later recoveries.
- R10: `err_cnt` counts accepted errors: each trigger plus each failing valid copy. `rec_cyc` counts every cycle in which the controller is not in `RS_IDLE`.
- R11: A write to N during a recovery does not change the number of copies of that recovery. It applies from the next trigger onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; its frequency is never changed by recovery |
| rst_n | input | 1 | Active-low synchronous reset |
| n_wr | input | 1 | Write strobe for the copy count N |
| n_wdata | input | NW (3) | New value for N, clamped to 1..DEPTH |
| wb_vld | input | 1 | Write-back result present this cycle |
| wb_seq | input | SEQ_W (4) | Sequence tag of the returning result |
| wb_err | input | 1 | Timing error flagged for the returning result |
| stall_o | output | 1 | Holds normal instruction issue |
| rpl_fire | output | 1 | A copy of the errant instruction is issued this cycle |
| rpl_replica | output | 1 | The current copy is a non-committing replica |
| rpl_seq | output | SEQ_W (4) | Sequence tag attached to the current copy |
| err_cnt | output | CNT_W (16) | Accepted error count |
| esc_cnt | output | CNT_W (16) | Escalation count |
| rec_cyc | output | CNT_W (16) | Total cycles spent recovering |
| fatal_o | output | 1 | Sticky flag: the escalated replay also failed |

## Verification
Every result depends on one register stage, so it is due one cycle after its cause:
- A trigger error sampled at an edge shows the first copy in the following cycle.
- Copy k of an attempt appears k cycles later.
- The valid copy's result shows as a drop of `stall_o`, or as the first escalated copy, one cycle after it is presented.

The bench drives inputs and samples outputs at the falling edge. Each stimulus therefore meets exactly one rising edge before its effect is read. The bench predicts the tag, the replica flag and the cycle count for each sampled cycle by counting those edges itself.

// File: rtl/rpl_pkg.sv
package rpl_pkg;

    typedef enum logic [1:0] {
        RS_IDLE  = 2'd0,
        RS_ISSUE = 2'd1,
        RS_WAIT  = 2'd2
    } rpl_state_e;

endpackage

// File: rtl/rpl_ncfg.sv
module rpl_ncfg #(
    parameter int DEPTH = 5,
    parameter int DEF_N = 2,
    parameter int NW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [NW-1:0] wdata,
    output logic [NW-1:0] n_q
);

    localparam logic [NW-1:0] N_MAX = NW'(DEPTH);
    localparam logic [NW-1:0] N_RST = NW'(DEF_N);

    logic [NW-1:0] clamped;

    always_comb begin
        if (wdata == '0)
            clamped = NW'(1);
        else if (wdata > N_MAX)
            clamped = N_MAX;
        else
            clamped = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            n_q <= N_RST;
        else if (wr)
            n_q <= clamped;
    end

    // R2
    n_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (n_q != '0) && (n_q <= N_MAX));

endmodule

// File: rtl/rpl_fsm.sv
module rpl_fsm
    import rpl_pkg::*;
#(
    parameter int DEPTH = 5,
    parameter int NW    = $clog2(DEPTH + 1),
    parameter int SEQ_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NW-1:0]    n_cur,
    input  logic             wb_vld,
    input  logic [SEQ_W-1:0] wb_seq,
    input  logic             wb_err,
    output logic             fire,
    output logic             replica,
    output logic [SEQ_W-1:0] seq,
    output logic             stall,
    output logic             acc_err,
    output logic             esc_pulse,
    output logic             fatal
);

    localparam logic [NW-1:0] N_DEPTH = NW'(DEPTH);
    localparam logic [NW-1:0] ONE_N   = NW'(1);

    rpl_state_e       state_q, state_d;
    logic [NW-1:0]    idx_q, idx_d;
    logic [NW-1:0]    tot_q, tot_d;
    logic             esc_q, esc_d;
    logic [SEQ_W-1:0] vseq_q, vseq_d;
    logic [SEQ_W-1:0] seq_q, seq_d;
    logic             fatal_q, fatal_d;
    logic             last_copy;
    logic             valid_hit;

    assign last_copy = (idx_q == tot_q - ONE_N);
    assign valid_hit = wb_vld && (wb_seq == vseq_q);

    // next-state and datapath decisions
    always_comb begin
        state_d   = state_q;
        idx_d     = idx_q;
        tot_d     = tot_q;
        esc_d     = esc_q;
        vseq_d    = vseq_q;
        seq_d     = seq_q;
        fatal_d   = fatal_q;
        acc_err   = 1'b0;
        esc_pulse = 1'b0;
        unique case (state_q)
            RS_IDLE: begin
                if (wb_vld && wb_err) begin
                    state_d = RS_ISSUE;
                    idx_d   = '0;
                    tot_d   = n_cur;
                    esc_d   = 1'b0;
                    acc_err = 1'b1;
                end
            end
            RS_ISSUE: begin
                seq_d = seq_q + SEQ_W'(1);
                idx_d = idx_q + ONE_N;
                if (last_copy) begin
                    vseq_d  = seq_q;
                    state_d = RS_WAIT;
                end
            end
            RS_WAIT: begin
                if (valid_hit) begin
                    if (!wb_err) begin
                        state_d = RS_IDLE;
                    end else if (!esc_q) begin
                        acc_err   = 1'b1;
                        esc_pulse = 1'b1;
                        esc_d     = 1'b1;
                        tot_d     = N_DEPTH;
                        idx_d     = '0;
                        state_d   = RS_ISSUE;
                    end else begin
                        acc_err = 1'b1;
                        fatal_d = 1'b1;
                        state_d = RS_IDLE;
                    end
                end
            end
            default: state_d = RS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
            idx_q   <= '0;
            tot_q   <= ONE_N;
            esc_q   <= 1'b0;
            vseq_q  <= '0;
            seq_q   <= '0;
            fatal_q <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            tot_q   <= tot_d;
            esc_q   <= esc_d;
            vseq_q  <= vseq_d;
            seq_q   <= seq_d;
            fatal_q <= fatal_d;
        end
    end

    // outputs
    always_comb begin
        fire    = 1'b0;
        replica = 1'b0;
        stall   = 1'b1;
        unique case (state_q)
            RS_IDLE:  stall = 1'b0;
            RS_ISSUE: begin
                fire    = 1'b1;
                replica = !last_copy;
            end
            RS_WAIT:  ;
            default:  stall = 1'b0;
        endcase
        seq   = seq_q;
        fatal = fatal_q;
    end

    // R4
    valid_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !replica) |=> !fire);

    // R3
    issue_gapless_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && replica) |=> fire);

    // R5
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (seq == $past(seq) + SEQ_W'(1)));

    // R7
    replica_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_WAIT && wb_vld && wb_seq != vseq_q) |=> (state_q == RS_WAIT));

    // R9
    fatal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fatal |=> fatal);

endmodule

// File: rtl/rpl_stats.sv
module rpl_stats #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy,
    input  logic             inc_err,
    input  logic             inc_esc,
    output logic [CNT_W-1:0] err_cnt,
    output logic [CNT_W-1:0] esc_cnt,
    output logic [CNT_W-1:0] rec_cyc
);

    localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_cnt <= '0;
            esc_cnt <= '0;
            rec_cyc <= '0;
        end else begin
            if (inc_err) err_cnt <= err_cnt + STEP;
            if (inc_esc) esc_cnt <= esc_cnt + STEP;
            if (busy)    rec_cyc <= rec_cyc + STEP;
        end
    end

    // R8
    esc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(esc_cnt) |-> (esc_cnt == $past(esc_cnt) + STEP));

    // R10
    rec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (rec_cyc == $past(rec_cyc) + STEP));

endmodule

// File: rtl/rpl_ctrl.sv
module rpl_ctrl #(
    parameter int DEPTH = 5,
    parameter int DEF_N = 2,
    parameter int SEQ_W = 4,
    parameter int CNT_W = 16,
    localparam int NW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             n_wr,
    input  logic [NW-1:0]    n_wdata,
    input  logic             wb_vld,
    input  logic [SEQ_W-1:0] wb_seq,
    input  logic             wb_err,
    output logic             stall_o,
    output logic             rpl_fire,
    output logic             rpl_replica,
    output logic [SEQ_W-1:0] rpl_seq,
    output logic [CNT_W-1:0] err_cnt,
    output logic [CNT_W-1:0] esc_cnt,
    output logic [CNT_W-1:0] rec_cyc,
    output logic             fatal_o
);

    logic [NW-1:0] n_cur;
    logic          acc_err;
    logic          esc_pulse;

    rpl_ncfg #(.DEPTH(DEPTH), .DEF_N(DEF_N), .NW(NW)) u_ncfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (n_wr),
        .wdata (n_wdata),
        .n_q   (n_cur)
    );

    rpl_fsm #(.DEPTH(DEPTH), .NW(NW), .SEQ_W(SEQ_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .n_cur     (n_cur),
        .wb_vld    (wb_vld),
        .wb_seq    (wb_seq),
        .wb_err    (wb_err),
        .fire      (rpl_fire),
        .replica   (rpl_replica),
        .seq       (rpl_seq),
        .stall     (stall_o),
        .acc_err   (acc_err),
        .esc_pulse (esc_pulse),
        .fatal     (fatal_o)
    );

    rpl_stats #(.CNT_W(CNT_W)) u_stats (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy    (stall_o),
        .inc_err (acc_err),
        .inc_esc (esc_pulse),
        .err_cnt (err_cnt),
        .esc_cnt (esc_cnt),
        .rec_cyc (rec_cyc)
    );

endmodule

// File: tb/sim_rpl_ctrl.sv
module sim_rpl_ctrl;

    localparam int DEPTH = 5;
    localparam int SEQ_W = 4;
    localparam int CNT_W = 16;
    localparam int NW    = $clog2(DEPTH + 1);

    // entry: [5:3] N written, [2] first valid errs, [1] escalated valid errs, [0] inject replica error
    localparam logic [5:0] TBL [7] = '{
        {3'd2, 1'b0, 1'b0, 1'b1},
        {3'd1, 1'b0, 1'b0, 1'b0},
        {3'd5, 1'b1, 1'b0, 1'b0},
        {3'd0, 1'b0, 1'b0, 1'b1},
        {3'd7, 1'b0, 1'b0, 1'b1},
        {3'd3, 1'b1, 1'b0, 1'b1},
        {3'd4, 1'b1, 1'b1, 1'b0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             n_wr = 1'b0;
    logic [NW-1:0]    n_wdata = '0;
    logic             wb_vld = 1'b0;
    logic [SEQ_W-1:0] wb_seq = '0;
    logic             wb_err = 1'b0;
    logic             stall_o, rpl_fire, rpl_replica, fatal_o;
    logic [SEQ_W-1:0] rpl_seq;
    logic [CNT_W-1:0] err_cnt, esc_cnt, rec_cyc;

    int n_chk = 0;
    int n_err = 0;
    int exp_seq = 0;
    int exp_err = 0;
    int exp_esc = 0;
    int exp_rec = 0;
    bit exp_fatal = 0;
    bit done = 0;

    always #2 clk = ~clk;

    rpl_ctrl #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .n_wr(n_wr), .n_wdata(n_wdata),
        .wb_vld(wb_vld), .wb_seq(wb_seq), .wb_err(wb_err),
        .stall_o(stall_o), .rpl_fire(rpl_fire), .rpl_replica(rpl_replica),
        .rpl_seq(rpl_seq), .err_cnt(err_cnt), .esc_cnt(esc_cnt),
        .rec_cyc(rec_cyc), .fatal_o(fatal_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk_counters(input string req);
        chk(int'(err_cnt) == exp_err, {req, " err_cnt"}, int'(err_cnt), exp_err);
        chk(int'(esc_cnt) == exp_esc, {req, " esc_cnt"}, int'(esc_cnt), exp_esc);
        chk(int'(rec_cyc) == exp_rec, {req, " rec_cyc"}, int'(rec_cyc), exp_rec);
        chk(fatal_o == exp_fatal, {req, " fatal_o"}, int'(fatal_o), int'(exp_fatal));
    endtask

    // one attempt of n copies; returns valid tag; optional N write during first copy
    task automatic issue_copies(input int n, input int mid_n, output int vseq);
        vseq = 0;
        for (int i = 0; i < n; i++) begin
            chk(rpl_fire == 1'b1, "R3 fire", int'(rpl_fire), 1);
            chk(stall_o == 1'b1, "R3 stall", int'(stall_o), 1);
            chk(rpl_replica == (i < n - 1), "R4 replica tag", int'(rpl_replica), int'(i < n - 1));
            chk(int'(rpl_seq) == exp_seq, "R5 seq tag", int'(rpl_seq), exp_seq);
            vseq = exp_seq;
            exp_seq = (exp_seq + 1) % (1 << SEQ_W);
            exp_rec++;
            if (i == 0 && mid_n != 0) begin
                n_wr = 1'b1;
                n_wdata = NW'(mid_n);
            end
            tick();
            n_wr = 1'b0;
        end
        chk(rpl_fire == 1'b0, "R6 fire low in wait", int'(rpl_fire), 0);
        chk(stall_o == 1'b1, "R6 stall in wait", int'(stall_o), 1);
    endtask

    // in wait: optional stray error, then valid result with err flag
    task automatic finish_attempt(input int vseq, input bit inj, input bit verr);
        if (inj) begin
            wb_vld = 1'b1;
            wb_err = 1'b1;
            wb_seq = SEQ_W'(vseq - 1);
            exp_rec++;
            tick();
            wb_vld = 1'b0;
            wb_err = 1'b0;
            chk(stall_o == 1'b1, "R7 stray error keeps wait", int'(stall_o), 1);
            chk(rpl_fire == 1'b0, "R7 stray error no escalation", int'(rpl_fire), 0);
            chk(int'(err_cnt) == exp_err, "R7 err_cnt unchanged", int'(err_cnt), exp_err);
        end
        wb_vld = 1'b1;
        wb_err = verr;
        wb_seq = SEQ_W'(vseq);
        exp_rec++;
        tick();
        wb_vld = 1'b0;
        wb_err = 1'b0;
    endtask

    task automatic run_rec(input int n_eff, input bit e1, input bit e2, input bit inj,
                           input int mid_n);
        int vseq;
        wb_vld = 1'b1;
        wb_err = 1'b1;
        wb_seq = '0;
        exp_err++;
        tick();
        wb_vld = 1'b0;
        wb_err = 1'b0;
        issue_copies(n_eff, mid_n, vseq);
        finish_attempt(vseq, inj, e1);
        if (e1) begin
            exp_err++;
            exp_esc++;
            chk(rpl_fire == 1'b1, "R8 escalation starts", int'(rpl_fire), 1);
            issue_copies(DEPTH, 0, vseq);
            finish_attempt(vseq, 1'b0, e2);
            if (e2) begin
                exp_err++;
                exp_fatal = 1'b1;
                chk(fatal_o == 1'b1, "R9 fatal set", int'(fatal_o), 1);
            end
        end
        chk(stall_o == 1'b0, "R6 released", int'(stall_o), 0);
        chk_counters("R10");
    endtask

    task automatic write_n(input int v);
        n_wr = 1'b1;
        n_wdata = NW'(v);
        tick();
        n_wr = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wb_vld = 1'b0;
        n_wr = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        exp_seq = 0; exp_err = 0; exp_esc = 0; exp_rec = 0; exp_fatal = 1'b0;
        tick();
    endtask

    initial begin
        int ncfg, neff;
        do_reset();
        // R1 reset state
        chk(stall_o == 1'b0, "R1 stall", int'(stall_o), 0);
        chk(rpl_fire == 1'b0, "R1 fire", int'(rpl_fire), 0);
        chk(rpl_replica == 1'b0, "R1 replica", int'(rpl_replica), 0);
        chk(int'(rpl_seq) == 0, "R1 seq", int'(rpl_seq), 0);
        chk_counters("R1");
        // R1 default N of 2
        run_rec(2, 1'b0, 1'b0, 1'b0, 0);

        for (int k = 0; k < 7; k++) begin
            ncfg = int'(TBL[k][5:3]);
            neff = (ncfg == 0) ? 1 : ((ncfg > DEPTH) ? DEPTH : ncfg);  // R2 clamp
            write_n(ncfg);
            run_rec(neff, TBL[k][2], TBL[k][1], TBL[k][0], 0);
        end

        // R9 fatal stays set through a later clean recovery
        write_n(3);
        run_rec(3, 1'b0, 1'b0, 1'b0, 0);
        chk(fatal_o == 1'b1, "R9 fatal sticky", int'(fatal_o), 1);

        // R11 write during recovery applies next time
        write_n(2);
        run_rec(2, 1'b0, 1'b0, 1'b0, 4);
        run_rec(4, 1'b0, 1'b0, 1'b0, 0);

        // R1 reset clears fatal and counters
        do_reset();
        chk_counters("R1 after reset");
        chk(int'(rpl_seq) == 0, "R1 seq after reset", int'(rpl_seq), 0);
        run_rec(2, 1'b0, 1'b0, 1'b0, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule